// File: doc/BRIEF.md
# Raw Sensor Line Capture Framer

The framer sits right behind the pins of a CMOS image sensor that sends raw Bayer pixels. Its inputs are a 10-bit pixel bus and a line-valid strobe. The sensor's frame-valid pin is not connected, so the framer finds frame boundaries by counting line-valid pulses against a programmed row count. It also counts pixels against a programmed column count.

Each accepted pixel leaves as a registered word with these markers:

- first pixel of a line
- last pixel of a line
- first pixel of a frame
- last pixel of a frame
- a two-bit Bayer site code

A one-cycle error pulse flags any line whose length does not match the programmed width.

Both sizes are given as the wanted count minus one. The supported range runs from 2 by 2 up to 2048 columns by 1536 rows. A parameter chooses the pixel clock edge on which the pins are sampled. Sampling on the falling edge adds one cycle of latency. Everything below assumes the default rising-edge sampling.

Top module: `raw_line_framer`

## Requirements
- R1: While `rst` is high, and on the edge after it, every output is 0. After reset a line is accepted only when `line_valid` has been seen low and then rises again. A line already high when reset is released yields no output.
- R2: A pixel sampled on clock edge k while its line is accepted appears on `o_pix` after edge k+1, with `o_valid` high. `o_valid` stays low while `line_valid` is low.
- R3: Pixel index 0 of a line carries `o_sol`. Index `col_size_m1` carries `o_eol`. Pixels beyond that index in an over-long line are dropped, so `o_valid` stays low for them.
- R4: The first line after reset is row 0. Each later rising edge advances the row. After row `row_size_m1` the next rising edge starts row 0 again. `o_sof` marks index 0 of row 0. `o_eof` marks index `col_size_m1` of row `row_size_m1`.
- R5: When `line_valid` is sampled low on edge k, at the end of a line whose pixel count is not `col_size_m1`+1, `o_len_err` is high for exactly the cycle after edge k+1. The line still counts as a row.
- R6: `o_phase[1]` is bit 0 of the row number and `o_phase[0]` is bit 0 of the pixel index. Both are counted from the start of the frame and the start of the line.
- R7: Every rising edge of `line_valid` starts a new line, even when the low gap between lines is a single cycle.
- R8: The smallest setting, 2 by 2 (both sizes 1), frames correctly: every second line closes a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| row_size_m1 | input | 11 | Rows per frame minus one |
| col_size_m1 | input | 11 | Pixels per line minus one |
| line_valid | input | 1 | High while the sensor drives line pixels |
| pix_in | input | 10 | Raw pixel sample |
| o_valid | output | 1 | Output word valid |
| o_pix | output | 10 | Pixel sample |
| o_sol | output | 1 | First pixel of a line |
| o_eol | output | 1 | Last pixel of a line |
| o_sof | output | 1 | First pixel of a frame |
| o_eof | output | 1 | Last pixel of a frame |
| o_len_err | output | 1 | One-cycle line length error |
| o_phase | output | 2 | Bayer site: {row parity, column parity} |

## Verification
Pixel words, markers and phase bits belong to the sample taken on edge k and are due after edge k+1. The length error belongs to the low sample that ends the line and is also due one edge later. The bench model consumes each sample at the edge where the design does. It pushes one expected word per edge and pops and compares that word at the following falling edge, while the registered outputs are stable. Frame, line and error totals taken over whole scenarios confirm the counting rules independently of per-cycle alignment.

// File: rtl/rlf_pkg.sv
package rlf_pkg;
  typedef struct packed {
    logic sol;
    logic eol;
    logic sof;
    logic eof;
  } rlf_marks_t;
endpackage

// File: rtl/rlf_sampler.sv
module rlf_sampler #(
  parameter int PIX_W   = 10,
  parameter bit ON_FALL = 1'b0
) (
  input  logic             clk,
  input  logic             lv_in,
  input  logic [PIX_W-1:0] d_in,
  output logic             s_lv,
  output logic [PIX_W-1:0] s_d
);
  generate
    if (ON_FALL) begin : g_fall
      logic             n_lv;
      logic [PIX_W-1:0] n_d;
      always_ff @(negedge clk) begin
        n_lv <= lv_in;
        n_d  <= d_in;
      end
      always_ff @(posedge clk) begin
        s_lv <= n_lv;
        s_d  <= n_d;
      end
    end else begin : g_rise
      always_ff @(posedge clk) begin
        s_lv <= lv_in;
        s_d  <= d_in;
      end
    end
  endgenerate
endmodule

// File: rtl/rlf_line_tracker.sv
module rlf_line_tracker #(
  parameter int COL_W = 11,
  localparam int CNT_W = COL_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_lv,
  input  logic [COL_W-1:0] col_m1,
  output logic             line_rise,
  output logic             pix_go,
  output logic [CNT_W-1:0] pix_idx,
  output logic             len_err
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             prev_lv;
  logic             armed;
  logic             in_line;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] want;

  assign want      = CNT_W'(col_m1) + CNT_W'(1);
  assign line_rise = s_lv && !prev_lv && armed;
  assign pix_go    = s_lv && (line_rise || in_line);
  assign pix_idx   = line_rise ? '0 : cnt;
  assign len_err   = !s_lv && in_line && (cnt != want);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_lv <= 1'b0;
      armed   <= 1'b0;
      in_line <= 1'b0;
      cnt     <= '0;
    end else begin
      prev_lv <= s_lv;
      if (!s_lv) armed <= 1'b1;
      if (line_rise) begin
        in_line <= 1'b1;
        cnt     <= CNT_W'(1);
      end else begin
        if (!s_lv) in_line <= 1'b0;
        if (s_lv && in_line && cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assert_rise_from_idle_R7: assert property (@(posedge clk) disable iff (rst)
    line_rise |-> !in_line);
  assert_wait_low_R1: assert property (@(posedge clk) disable iff (rst)
    !armed |-> !in_line);
  assert_rise_starts_count_R3: assert property (@(posedge clk) disable iff (rst)
    line_rise |=> (in_line && cnt == CNT_W'(1)));
endmodule

// File: rtl/rlf_frame_tracker.sv
module rlf_frame_tracker #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_rise,
  input  logic [ROW_W-1:0] row_m1,
  output logic [ROW_W-1:0] cur_row
);
  logic             started;
  logic [ROW_W-1:0] row_cnt;
  logic [ROW_W-1:0] nxt_row;

  assign nxt_row = (!started || row_cnt >= row_m1) ? '0 : row_cnt + ROW_W'(1);
  assign cur_row = line_rise ? nxt_row : row_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      started <= 1'b0;
      row_cnt <= '0;
    end else if (line_rise) begin
      started <= 1'b1;
      row_cnt <= nxt_row;
    end
  end

  assert_first_line_row0_R4: assert property (@(posedge clk) disable iff (rst)
    (line_rise && !started) |=> (started && row_cnt == '0));
  assert_row_held_R4: assert property (@(posedge clk) disable iff (rst)
    !line_rise |=> $stable(row_cnt));
endmodule

// File: rtl/raw_line_framer.sv
module raw_line_framer #(
  parameter int PIX_W          = 10,
  parameter int COL_W          = 11,
  parameter int ROW_W          = 11,
  parameter bit SAMPLE_ON_FALL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ROW_W-1:0] row_size_m1,
  input  logic [COL_W-1:0] col_size_m1,
  input  logic             line_valid,
  input  logic [PIX_W-1:0] pix_in,
  output logic             o_valid,
  output logic [PIX_W-1:0] o_pix,
  output logic             o_sol,
  output logic             o_eol,
  output logic             o_sof,
  output logic             o_eof,
  output logic             o_len_err,
  output logic [1:0]       o_phase
);
  import rlf_pkg::*;
  localparam int CNT_W = COL_W + 1;

  logic             s_lv;
  logic [PIX_W-1:0] s_d;
  logic             line_rise;
  logic             pix_go;
  logic [CNT_W-1:0] pix_idx;
  logic             len_err;
  logic [ROW_W-1:0] cur_row;
  logic             take;
  logic             first_px;
  logic             last_px;
  rlf_marks_t       marks;

  rlf_sampler #(.PIX_W(PIX_W), .ON_FALL(SAMPLE_ON_FALL)) u_smp (
    .clk(clk), .lv_in(line_valid), .d_in(pix_in), .s_lv(s_lv), .s_d(s_d));

  rlf_line_tracker #(.COL_W(COL_W)) u_line (
    .clk(clk), .rst(rst), .s_lv(s_lv), .col_m1(col_size_m1),
    .line_rise(line_rise), .pix_go(pix_go), .pix_idx(pix_idx), .len_err(len_err));

  rlf_frame_tracker #(.ROW_W(ROW_W)) u_frame (
    .clk(clk), .rst(rst), .line_rise(line_rise), .row_m1(row_size_m1),
    .cur_row(cur_row));

  assign take      = pix_go && (pix_idx <= CNT_W'(col_size_m1));
  assign first_px  = take && (pix_idx == '0);
  assign last_px   = take && (pix_idx == CNT_W'(col_size_m1));
  assign marks.sol = first_px;
  assign marks.eol = last_px;
  assign marks.sof = first_px && (cur_row == '0);
  assign marks.eof = last_px && (cur_row == row_size_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid   <= 1'b0;
      o_pix     <= '0;
      o_sol     <= 1'b0;
      o_eol     <= 1'b0;
      o_sof     <= 1'b0;
      o_eof     <= 1'b0;
      o_len_err <= 1'b0;
      o_phase   <= 2'b00;
    end else begin
      o_valid   <= take;
      o_pix     <= take ? s_d : '0;
      o_sol     <= marks.sol;
      o_eol     <= marks.eol;
      o_sof     <= marks.sof;
      o_eof     <= marks.eof;
      o_len_err <= len_err;
      o_phase   <= take ? {cur_row[0], pix_idx[0]} : 2'b00;
    end
  end

  assert_err_single_R5: assert property (@(posedge clk) disable iff (rst)
    o_len_err |=> !o_len_err);
  assert_marks_need_valid_R3: assert property (@(posedge clk) disable iff (rst)
    (o_sol || o_eol || o_sof || o_eof) |-> o_valid);
  assert_sof_phase_R6: assert property (@(posedge clk) disable iff (rst)
    o_sof |-> (o_phase == 2'b00 && o_sol));
  assert_eof_is_eol_R4: assert property (@(posedge clk) disable iff (rst)
    o_eof |-> o_eol);
endmodule

// File: tb/sim_raw_line_framer.sv
module sim_raw_line_framer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] row_size_m1 = 11'd3;
  logic [10:0] col_size_m1 = 11'd7;
  logic        line_valid = 1'b0;
  logic [9:0]  pix_in = '0;
  logic        o_valid, o_sol, o_eol, o_sof, o_eof, o_len_err;
  logic [9:0]  o_pix;
  logic [1:0]  o_phase;

  always #5 clk = ~clk;

  raw_line_framer u0 (
    .clk(clk), .rst(rst), .row_size_m1(row_size_m1), .col_size_m1(col_size_m1),
    .line_valid(line_valid), .pix_in(pix_in), .o_valid(o_valid), .o_pix(o_pix),
    .o_sol(o_sol), .o_eol(o_eol), .o_sof(o_sof), .o_eof(o_eof),
    .o_len_err(o_len_err), .o_phase(o_phase));

  typedef struct {
    bit v; int d; bit sol; bit eol; bit sof; bit eof; bit err; int ph;
  } exp_t;

  exp_t exp_q[$];
  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural model state
  bit m_last_lv = 0;
  int m_last_d = 0;
  bit m_prev = 0, m_armed = 0, m_inl = 0, m_started = 0;
  int m_cnt = 0, m_row = 0;

  int n_v = 0, n_sol = 0, n_sof = 0, n_eof = 0, n_err = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cycles);
    end
  endtask

  always @(posedge clk) begin
    exp_t e;
    bit rise, go, take;
    int idx;
    cycles++;
    e = '{0, 0, 0, 0, 0, 0, 0, 0};
    if (rst) begin
      m_prev = 0; m_armed = 0; m_inl = 0; m_started = 0; m_cnt = 0; m_row = 0;
    end else begin
      rise = m_last_lv && !m_prev && m_armed;
      if (rise) begin
        m_row = (!m_started || m_row >= int'(row_size_m1)) ? 0 : m_row + 1;
        m_started = 1;
        idx = 0;
      end else idx = m_cnt;
      go   = m_last_lv && (rise || m_inl);
      take = go && (idx <= int'(col_size_m1));
      e.err = !m_last_lv && m_inl && (m_cnt != int'(col_size_m1) + 1);
      if (take) begin
        e.v = 1; e.d = m_last_d;
        e.sol = (idx == 0);
        e.eol = (idx == int'(col_size_m1));
        e.sof = e.sol && (m_row == 0);
        e.eof = e.eol && (m_row == int'(row_size_m1));
        e.ph  = (m_row % 2) * 2 + (idx % 2);
      end
      if (rise) begin m_inl = 1; m_cnt = 1; end
      else begin
        if (!m_last_lv) m_inl = 0;
        if (m_last_lv && m_inl && m_cnt < 4095) m_cnt++;
      end
      if (!m_last_lv) m_armed = 1;
      m_prev = m_last_lv;
    end
    m_last_lv = line_valid;
    m_last_d  = int'(pix_in);
    exp_q.push_back(e);
  end

  always @(negedge clk) begin
    exp_t e;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      check(o_valid == e.v, "R2 valid", o_valid, e.v);
      if (e.v) check(int'(o_pix) == e.d, "R2 pixel", o_pix, e.d);
      check(o_sol == e.sol, "R3 sol", o_sol, e.sol);
      check(o_eol == e.eol, "R3 eol", o_eol, e.eol);
      check(o_sof == e.sof, "R4 sof", o_sof, e.sof);
      check(o_eof == e.eof, "R4 eof", o_eof, e.eof);
      check(o_len_err == e.err, "R5 len_err", o_len_err, e.err);
      check(int'(o_phase) == e.ph, "R6 phase", o_phase, e.ph);
    end
    n_v += o_valid; n_sol += o_sol; n_sof += o_sof; n_eof += o_eof; n_err += o_len_err;
  end

  always @(posedge clk) begin
    if (cycles > 50000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic send_line(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      line_valid = 1'b1;
      pix_in = 10'($urandom);
    end
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      line_valid = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int b_v, b_sol, b_sof, b_eof, b_err;
    line_valid = 1'b1;
    idle(4);
    // R1: reset state
    check({o_valid, o_sol, o_eol, o_sof, o_eof, o_len_err} == 6'b0, "R1 reset outputs",
          {o_valid, o_sol, o_eol, o_sof, o_eof, o_len_err}, 0);
    rst = 1'b0;
    b_v = n_v;
    idle(6);
    line_valid = 1'b0;
    idle(3);
    check(n_v == b_v, "R1 line high at release ignored", n_v - b_v, 0);

    // R4: two frames, 4 rows of 8 pixels, gapped lines
    b_sof = n_sof; b_eof = n_eof; b_sol = n_sol;
    for (int l = 0; l < 8; l++) send_line(8, 3);
    idle(4);
    check(n_sof - b_sof == 2, "R4 frame starts", n_sof - b_sof, 2);
    check(n_eof - b_eof == 2, "R4 frame ends", n_eof - b_eof, 2);
    check(n_sol - b_sol == 8, "R3 line starts", n_sol - b_sol, 8);

    // R7: one-cycle gaps between lines
    b_sol = n_sol; b_sof = n_sof;
    for (int l = 0; l < 4; l++) send_line(8, 1);
    idle(4);
    check(n_sol - b_sol == 4, "R7 one-cycle gap lines", n_sol - b_sol, 4);
    check(n_sof - b_sof == 1, "R7 frame start", n_sof - b_sof, 1);

    // R5: short and long lines still counted
    b_err = n_err; b_v = n_v; b_eof = n_eof;
    send_line(5, 2);
    send_line(10, 2);
    send_line(8, 2);
    send_line(8, 2);
    idle(4);
    check(n_err - b_err == 2, "R5 length errors", n_err - b_err, 2);
    check(n_v - b_v == 29, "R3 extra pixels dropped", n_v - b_v, 29);
    check(n_eof - b_eof == 1, "R5 bad lines counted", n_eof - b_eof, 1);

    // R8: smallest frame
    @(negedge clk);
    rst = 1'b1;
    row_size_m1 = 11'd1;
    col_size_m1 = 11'd1;
    idle(3);
    rst = 1'b0;
    idle(2);
    b_sof = n_sof; b_eof = n_eof; b_err = n_err;
    for (int l = 0; l < 4; l++) send_line(2, 2);
    idle(4);
    check(n_sof - b_sof == 2, "R8 2x2 frame starts", n_sof - b_sof, 2);
    check(n_eof - b_eof == 2, "R8 2x2 frame ends", n_eof - b_eof, 2);
    check(n_err - b_err == 0, "R8 2x2 no errors", n_err - b_err, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule